// File: doc/BRIEF.md
# Word-Packed SPI Byte Buffer

This block sits between a 32-bit register port and a byte-serial SPI shift engine. Software writes transmit data as whole words into one port. The buffer then presents those words to the engine one byte at a time. In the other direction, the engine delivers received bytes one at a time, and the buffer packs them into words that software reads from a single port. Each direction stores 32 bytes, which is eight words.

The byte order inside a word is set separately for each direction. With the order bit clear, the least significant byte travels first. With it set, the most significant byte travels first. A transfer whose length is not a multiple of four ends in a partial word. On transmit, the engine stops taking bytes after the last meaningful one, and a clear discards the rest of that word. On receive, the engine raises a flush strobe, and the partly filled word is stored with its unused byte positions at zero.

Top module: `spi_word_buf`

## Requirements
- R1: The transmit side holds eight words (32 bytes). After eight writes with no bytes taken, `tx_full` is high, and a ninth write leaves no trace in the byte stream.
- R2: With `tx_msb_first` low, the bytes of each word leave in the order bits 7:0, 15:8, 23:16, 31:24. `tx_byte` shows the current byte while `tx_byte_valid` is high, and `tx_take` advances it.
- R3: With `tx_msb_first` high, the bytes leave in the order bits 31:24, 23:16, 15:8, 7:0.
- R4: With `rx_msb_first` low, the k-th byte pushed into a word (k = 0..3) lands in bits 8k+7:8k.
- R5: With `rx_msb_first` high, the k-th byte pushed into a word lands in bits 8(3-k)+7:8(3-k).
- R6: `rx_flush` with one to three bytes gathered stores that word, and its unused byte positions read zero. A flush with no bytes gathered stores nothing. A byte pushed in the same cycle as a flush is included in the stored word.
- R7: A word write while `tx_full` is high is dropped and sets `tx_ovf`. The flag stays set until a clear, and the stored data is left intact.
- R8: When the receive side is empty, `rx_rdata` reads zero. A read while empty sets `rx_udf`, which stays set until a clear.
- R9: `clr` empties both directions, resets both byte-lane pointers, discards a partly taken or partly gathered word, and clears both sticky flags.
- R10: `tx_take` while `tx_byte_valid` is low has no effect. The next word written starts at its first byte.
- R11: The receive side holds eight words, and `rx_full` is high when all eight are present. A word completed while it is full is dropped, and the stored words are unchanged.
- R12: `rx_rdata` shows the oldest stored word in the cycle after it completes. `rx_rd` removes that word and exposes the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of both directions and flags |
| tx_msb_first | input | 1 | Transmit byte order: 1 sends the most significant byte first |
| rx_msb_first | input | 1 | Receive byte order: 1 fills the most significant byte first |
| tx_wr | input | 1 | Word write strobe, transmit side |
| tx_wdata | input | 32 | Word written to the transmit side |
| tx_full | output | 1 | Transmit side holds eight words |
| tx_ovf | output | 1 | Sticky: a word write was dropped |
| tx_byte_valid | output | 1 | A transmit byte is available |
| tx_byte | output | 8 | Current transmit byte |
| tx_take | input | 1 | Engine consumes the current transmit byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_flush | input | 1 | Store the partly gathered receive word |
| rx_full | output | 1 | Receive side holds eight words |
| rx_empty | output | 1 | Receive side holds no word |
| rx_rd | input | 1 | Word read strobe, receive side |
| rx_rdata | output | 32 | Oldest received word, zero when empty |
| rx_udf | output | 1 | Sticky: a read found the receive side empty |

## Verification
The main check is a loopback. Each transmitted byte is fed straight back into the receive side, and this is done with words that have distinct byte values under all four combinations of the two order bits. Matching orders must return the word unchanged, and mismatched orders must return it byte-reversed. This separates a lane that was swapped in only one direction from a lane that was swapped in both. Partial words are built with one, two and three bytes in both orders, including a flush in the same cycle as a byte push, which shows whether padding and the final byte are placed correctly. Filling each side past eight words and then draining it, with a sequential byte pattern, shows whether a dropped word leaks into the stream or disturbs the word order.

// File: rtl/spi_word_buf_pkg.sv
package spi_word_buf_pkg;

  // Byte position inside a word for the lane-th byte on the wire.
  function automatic int unsigned byte_slot(input int unsigned lane,
                                            input logic msb_first,
                                            input int unsigned nbytes);
    return msb_first ? (nbytes - 1 - lane) : lane;
  endfunction

endpackage

// File: rtl/spi_word_buf_ring.sv
module spi_word_buf_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/spi_word_buf_tx.sv
module spi_word_buf_tx
  import spi_word_buf_pkg::*;
#(
  parameter int WB    = 4,
  parameter int DEPTH = 8,
  localparam int DW   = 8 * WB,
  localparam int LW   = (WB > 1) ? $clog2(WB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          msb_first,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          take,
  output logic          byte_valid,
  output logic [7:0]    byte_out,
  output logic          full,
  output logic          ovf,
  output logic          pop_evt
);
  logic [DW-1:0] head;
  logic          empty;
  logic [LW-1:0] lane_q;
  logic          take_ok, last_lane;

  spi_word_buf_ring #(.W(DW), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(wr), .din(wdata), .pop(pop_evt),
    .dout(head), .full(full), .empty(empty)
  );

  assign byte_valid = !empty;
  assign take_ok    = take && !empty;
  assign last_lane  = (lane_q == LW'(WB - 1));
  assign pop_evt    = take_ok && last_lane;

  always_comb begin
    byte_out = head[8*byte_slot(int'(lane_q), msb_first, WB) +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
      ovf    <= 1'b0;
    end else if (clr) begin
      lane_q <= '0;
      ovf    <= 1'b0;
    end else begin
      if (take_ok) lane_q <= last_lane ? '0 : lane_q + LW'(1);
      if (wr && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_word_buf_rx.sv
module spi_word_buf_rx
  import spi_word_buf_pkg::*;
#(
  parameter int WB    = 4,
  parameter int DEPTH = 8,
  localparam int DW   = 8 * WB,
  localparam int NW   = $clog2(WB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          msb_first,
  input  logic          push,
  input  logic [7:0]    byte_in,
  input  logic          flush,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          empty,
  output logic          udf,
  output logic          word_evt
);
  logic [DW-1:0] asm_q, asm_nx, head;
  logic [NW-1:0] n_q, n_nx;

  always_comb begin
    asm_nx = asm_q;
    n_nx   = n_q;
    if (push) begin
      asm_nx[8*byte_slot(int'(n_q), msb_first, WB) +: 8] = byte_in;
      n_nx = n_q + NW'(1);
    end
    word_evt = (n_nx == NW'(WB)) || (flush && n_nx != '0);
  end

  spi_word_buf_ring #(.W(DW), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(word_evt), .din(asm_nx), .pop(rd),
    .dout(head), .full(full), .empty(empty)
  );

  assign rdata = empty ? '0 : head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= '0;
      n_q   <= '0;
      udf   <= 1'b0;
    end else if (clr) begin
      asm_q <= '0;
      n_q   <= '0;
      udf   <= 1'b0;
    end else begin
      asm_q <= word_evt ? '0 : asm_nx;
      n_q   <= word_evt ? '0 : n_nx;
      if (rd && empty) udf <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_word_buf.sv
module spi_word_buf #(
  parameter int DEPTH_BYTES = 32,
  parameter int WORD_BYTES  = 4,
  localparam int DW         = 8 * WORD_BYTES,
  localparam int DEPTH_W    = DEPTH_BYTES / WORD_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tx_msb_first,
  input  logic          rx_msb_first,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  output logic          tx_full,
  output logic          tx_ovf,
  output logic          tx_byte_valid,
  output logic [7:0]    tx_byte,
  input  logic          tx_take,
  input  logic          rx_push,
  input  logic [7:0]    rx_byte,
  input  logic          rx_flush,
  output logic          rx_full,
  output logic          rx_empty,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_rdata,
  output logic          rx_udf
);
  logic tx_pop_evt;
  logic rx_word_evt;

  spi_word_buf_tx #(.WB(WORD_BYTES), .DEPTH(DEPTH_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .msb_first(tx_msb_first),
    .wr(tx_wr), .wdata(tx_wdata), .take(tx_take),
    .byte_valid(tx_byte_valid), .byte_out(tx_byte),
    .full(tx_full), .ovf(tx_ovf), .pop_evt(tx_pop_evt)
  );

  spi_word_buf_rx #(.WB(WORD_BYTES), .DEPTH(DEPTH_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .msb_first(rx_msb_first),
    .push(rx_push), .byte_in(rx_byte), .flush(rx_flush), .rd(rx_rd),
    .rdata(rx_rdata), .full(rx_full), .empty(rx_empty),
    .udf(rx_udf), .word_evt(rx_word_evt)
  );
endmodule

// File: rtl/spi_word_buf_chk.sv
module spi_word_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       tx_msb_first,
  input logic       tx_wr,
  input logic       tx_full,
  input logic       tx_ovf,
  input logic       tx_byte_valid,
  input logic [7:0] tx_byte,
  input logic       tx_take,
  input logic       tx_pop_evt,
  input logic       rx_rd,
  input logic       rx_empty,
  input logic       rx_full,
  input logic       rx_udf,
  input logic       rx_word_evt
);
  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && tx_full && !clr |=> tx_ovf);

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf && !clr |=> tx_ovf);

  p_udf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd && rx_empty && !clr |=> rx_udf);

  p_clr_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> rx_empty && !tx_byte_valid && !tx_ovf && !rx_udf);

  p_hold_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_byte_valid && !tx_take && !clr ##1 $stable(tx_msb_first) |-> $stable(tx_byte));

  p_pop_needs_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_evt |-> tx_byte_valid && tx_take);

  p_rx_full_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word_evt && rx_full && !rx_rd && !clr |=> rx_full);
endmodule

bind spi_word_buf spi_word_buf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .tx_msb_first(tx_msb_first),
  .tx_wr(tx_wr), .tx_full(tx_full), .tx_ovf(tx_ovf),
  .tx_byte_valid(tx_byte_valid), .tx_byte(tx_byte), .tx_take(tx_take),
  .tx_pop_evt(tx_pop_evt), .rx_rd(rx_rd), .rx_empty(rx_empty),
  .rx_full(rx_full), .rx_udf(rx_udf), .rx_word_evt(rx_word_evt)
);

// File: tb/spi_word_buf_bench.sv
module spi_word_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        tx_msb_first = 1'b0, rx_msb_first = 1'b0;
  logic        tx_wr = 1'b0;
  logic [31:0] tx_wdata = '0;
  logic        tx_full, tx_ovf, tx_byte_valid;
  logic [7:0]  tx_byte;
  logic        tx_take = 1'b0;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_flush = 1'b0;
  logic        rx_full, rx_empty;
  logic        rx_rd = 1'b0;
  logic [31:0] rx_rdata;
  logic        rx_udf;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  spi_word_buf u_spi_word_buf (.*);

  // {tx order, rx order, word}
  localparam logic [33:0] VEC [8] = '{
    {1'b0, 1'b0, 32'hA1B2C3D4}, {1'b1, 1'b1, 32'h0F1E2D3C},
    {1'b0, 1'b1, 32'h11223344}, {1'b1, 1'b0, 32'hDEADBEEF},
    {1'b0, 1'b0, 32'h80000001}, {1'b1, 1'b0, 32'h01020304},
    {1'b0, 1'b1, 32'hFF00AA55}, {1'b1, 1'b1, 32'h13579BDF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [31:0] swap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic wr_word(input logic [31:0] w);
    tx_wr = 1'b1; tx_wdata = w; step(); tx_wr = 1'b0;
  endtask

  task automatic push_b(input logic [7:0] b, input logic fl);
    rx_push = 1'b1; rx_byte = b; rx_flush = fl; step();
    rx_push = 1'b0; rx_flush = 1'b0;
  endtask

  task automatic do_clr();
    clr = 1'b1; step(); clr = 1'b0;
  endtask

  task automatic rd_word();
    rx_rd = 1'b1; step(); rx_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9 reset state
    chk("R9 reset byte_valid", 32'(tx_byte_valid), 0);
    chk("R9 reset rx_empty", 32'(rx_empty), 1);
    chk("R9 reset flags", {30'd0, tx_ovf, rx_udf}, 0);
    chk("R8 empty rdata zero", rx_rdata, 0);

    // Loopback table: R2 R3 R4 R5 R12
    foreach (VEC[i]) begin
      logic [31:0] w;
      w = VEC[i][31:0];
      tx_msb_first = VEC[i][33];
      rx_msb_first = VEC[i][32];
      wr_word(w);
      for (int k = 0; k < 4; k++) begin
        logic [7:0] eb;
        eb = tx_msb_first ? w[8*(3-k) +: 8] : w[8*k +: 8];
        chk(tx_msb_first ? "R3 tx byte order" : "R2 tx byte order", 32'(tx_byte), 32'(eb));
        tx_take = 1'b1; rx_push = 1'b1; rx_byte = tx_byte;
        step();
        tx_take = 1'b0; rx_push = 1'b0;
      end
      chk(rx_msb_first ? "R5 rx pack" : "R4 rx pack", rx_rdata,
          (tx_msb_first == rx_msb_first) ? w : swap(w));
      rd_word();
      chk("R12 read pops", 32'(rx_empty), 1);
    end

    // R1 / R7: fill transmit side past capacity
    tx_msb_first = 1'b0;
    for (int i = 0; i < 8; i++) wr_word(32'h10203040 + 32'(i));
    chk("R1 tx_full after eight", 32'(tx_full), 1);
    chk("R7 no ovf before drop", 32'(tx_ovf), 0);
    wr_word(32'hCAFEF00D);
    chk("R7 ovf set", 32'(tx_ovf), 1);
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] w;
        w = 32'h10203040 + 32'(i);
        chk("R1 R7 stored data intact", 32'(tx_byte), 32'(w[8*k +: 8]));
        tx_take = 1'b1; step(); tx_take = 1'b0;
      end
    end
    chk("R1 ninth word absent", 32'(tx_byte_valid), 0);
    chk("R7 ovf sticky", 32'(tx_ovf), 1);
    do_clr();
    chk("R9 clr clears ovf", 32'(tx_ovf), 0);

    // R10: take while empty ignored
    tx_take = 1'b1; step(); tx_take = 1'b0;
    wr_word(32'hA1B2C3D4);
    chk("R10 empty take ignored", 32'(tx_byte), 32'hD4);

    // R9: partly taken word discarded by clear
    tx_take = 1'b1; step(); step(); tx_take = 1'b0;
    do_clr();
    chk("R9 clr empties tx", 32'(tx_byte_valid), 0);
    wr_word(32'h55667788);
    chk("R9 lane reset", 32'(tx_byte), 32'h88);
    do_clr();

    // R6 partial words
    rx_msb_first = 1'b0;
    push_b(8'h11, 1'b0); push_b(8'h22, 1'b0);
    rx_flush = 1'b1; step(); rx_flush = 1'b0;
    chk("R6 partial lsb", rx_rdata, 32'h00002211);
    rd_word();
    rx_msb_first = 1'b1;
    push_b(8'hAA, 1'b0); push_b(8'hBB, 1'b0); push_b(8'hCC, 1'b0);
    rx_flush = 1'b1; step(); rx_flush = 1'b0;
    chk("R6 partial msb", rx_rdata, 32'hAABBCC00);
    rd_word();
    rx_flush = 1'b1; step(); rx_flush = 1'b0;
    chk("R6 empty flush stores nothing", 32'(rx_empty), 1);
    rx_msb_first = 1'b0;
    push_b(8'h55, 1'b0); push_b(8'h66, 1'b1);
    chk("R6 flush with push", rx_rdata, 32'h00006655);
    rd_word();
    rx_msb_first = 1'b1;
    push_b(8'h9C, 1'b1);
    chk("R6 single byte msb", rx_rdata, 32'h9C000000);
    rd_word();

    // R8 underflow
    chk("R8 empty rdata zero", rx_rdata, 0);
    rd_word();
    chk("R8 udf set", 32'(rx_udf), 1);
    step();
    chk("R8 udf sticky", 32'(rx_udf), 1);

    // R9: partly gathered receive word discarded
    rx_msb_first = 1'b0;
    push_b(8'hEE, 1'b0); push_b(8'hEF, 1'b0);
    do_clr();
    chk("R9 clr clears udf", 32'(rx_udf), 0);
    for (int k = 0; k < 4; k++) push_b(8'h31 + 8'(k), 1'b0);
    chk("R9 rx lane reset", rx_rdata, 32'h34333231);
    rd_word();

    // R11 receive capacity
    for (int i = 0; i < 36; i++) push_b(8'(i), 1'b0);
    chk("R11 rx_full", 32'(rx_full), 1);
    for (int j = 0; j < 8; j++) begin
      logic [31:0] e;
      e = {8'(4*j+3), 8'(4*j+2), 8'(4*j+1), 8'(4*j)};
      chk("R11 R12 word order", rx_rdata, e);
      rd_word();
    end
    chk("R11 extra word dropped", 32'(rx_empty), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule